// File: doc/BRIEF.md
# Phase-Tracking Multi-Context Lookup Table

This block is a two-operand lookup table that holds one four-entry truth table for each of several contexts, eight by default. A context number picks the active table. The two operand bits then pick one entry of that table. Operands and result travel as level-encoded dual-rail pairs. In each pair the value rail carries the data bit, and the XOR of the value and return rails carries the phase. Each operand also has a flag wire that marks a bit as a context-ID bit rather than a data bit.

The block is modelled synchronously. In state `ST_IDLE` it waits for a new token. A new token is present when both flags are low, the two operand phases agree, and that common phase differs from the phase the output now carries. The transition IDLE→EVAL captures the operand bits, the phase and the context number. In state `ST_EVAL` the selected entry is encoded with the captured phase and driven out, and the transition EVAL→IDLE follows unconditionally. In all other cases the output holds its value. The truth tables are loaded through a write port that is ignored during `ST_EVAL`.

Top module: `phase_lut_mc`

## Requirements
- R1: While reset is asserted and after its release, the output is y_v = 0 and y_r = 0, every stored table bit is 0, and the block is in ST_IDLE.
- R2: When cfg_we is high on a clock edge in ST_IDLE, cfg_din is stored at table address cfg_addr = {context[2:0], entry[1:0]}.
- R3: An evaluation starts on the edge that sees a_c = b_c = 0, equal operand phases, and a common phase that differs from the output phase (y_v ^ y_r). The output changes on the next edge and not before.
- R4: The result bit is the table entry at address {context, a_v, b_v}, so operand a is the most significant entry bit. The context is the value ctx_id held on the edge that started the evaluation.
- R5: The output has y_v = result bit and y_r = result bit XOR captured phase. Input phase 0 therefore gives y_r = y_v, and input phase 1 gives y_r = not y_v.
- R6: While the two operand phases differ, no evaluation starts and the output holds.
- R7: While either flag a_c or b_c is 1, no evaluation starts and the output holds. Once both flags return to 0, a pending token is evaluated.
- R8: A configuration write issued during ST_EVAL is discarded and leaves the stored table unchanged.
- R9: A change of ctx_id during ST_EVAL does not affect the result being produced. It selects the table for the next evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_v | input | 1 | Operand a value rail |
| a_r | input | 1 | Operand a return rail |
| a_c | input | 1 | Operand a context-bit flag |
| b_v | input | 1 | Operand b value rail |
| b_r | input | 1 | Operand b return rail |
| b_c | input | 1 | Operand b context-bit flag |
| ctx_id | input | 3 | Context number selecting the truth table |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | 5 | Table write address {context, entry} |
| cfg_din | input | 1 | Table write data |
| y_v | output | 1 | Result value rail |
| y_r | output | 1 | Result return rail |

## Verification
The bench builds the block with its default of eight contexts. With that value the three-bit context field covers every table exactly, so all 32 stored bits can be written, read back through evaluations, and compared against a bench-side model of the tables. Random tokens alternate the input phase over every context and operand pair. Directed cases hold the operands in a split-phase state or with a raised flag, and issue writes and context changes during the evaluation cycle.

// File: rtl/plut_pkg.sv
package plut_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1
    } lut_state_e;

    function automatic logic pair_phase(input logic v, input logic r);
        return v ^ r;
    endfunction

endpackage

// File: rtl/ledr_rx.sv
module ledr_rx (
    input  logic v_i,
    input  logic r_i,
    input  logic c_i,
    output logic data_o,
    output logic phase_o,
    output logic is_data_o
);
    import plut_pkg::*;

    always_comb begin
        data_o    = v_i;
        phase_o   = pair_phase(v_i, r_i);
        is_data_o = ~c_i;
    end
endmodule

// File: rtl/lut_cfg_store.sv
module lut_cfg_store #(
    parameter int NUM_CTX = 8,
    parameter int ENT     = 4,
    localparam int NBITS  = NUM_CTX * ENT,
    localparam int ADDR_W = $clog2(NBITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_bit,
    output logic [NBITS-1:0]  planes
);
    for (genvar g = 0; g < NBITS; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                planes[g] <= 1'b0;
            else if (wr_en && (wr_addr == ADDR_W'(g)))
                planes[g] <= wr_bit;
        end
    end
endmodule

// File: rtl/lut_plane_sel.sv
module lut_plane_sel #(
    parameter int NUM_CTX = 8,
    parameter int ENT     = 4,
    localparam int NBITS  = NUM_CTX * ENT,
    localparam int CTX_W  = $clog2(NUM_CTX),
    localparam int IDX_W  = $clog2(ENT)
) (
    input  logic [NBITS-1:0] planes,
    input  logic [CTX_W-1:0] ctx,
    input  logic [IDX_W-1:0] idx,
    output logic             bit_o
);
    always_comb bit_o = planes[{ctx, idx}];
endmodule

// File: rtl/phase_lut_mc.sv
module phase_lut_mc #(
    parameter int NUM_CTX = 8,
    localparam int ENT    = 4,
    localparam int CTX_W  = $clog2(NUM_CTX),
    localparam int IDX_W  = $clog2(ENT),
    localparam int ADDR_W = CTX_W + IDX_W,
    localparam int NBITS  = NUM_CTX * ENT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_v,
    input  logic              a_r,
    input  logic              a_c,
    input  logic              b_v,
    input  logic              b_r,
    input  logic              b_c,
    input  logic [CTX_W-1:0]  ctx_id,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_din,
    output logic              y_v,
    output logic              y_r
);
    import plut_pkg::*;

    lut_state_e st_q, st_d;

    logic a_dat, a_ph, a_ok;
    logic b_dat, b_ph, b_ok;
    logic trig;
    logic out_ph;

    logic [IDX_W-1:0] idx_q;
    logic [CTX_W-1:0] ctx_q;
    logic             ph_q;
    logic [NBITS-1:0] planes_w;
    logic             sel_bit;
    logic             wr_ok;

    ledr_rx u_rx_a (.v_i(a_v), .r_i(a_r), .c_i(a_c),
                    .data_o(a_dat), .phase_o(a_ph), .is_data_o(a_ok));
    ledr_rx u_rx_b (.v_i(b_v), .r_i(b_r), .c_i(b_c),
                    .data_o(b_dat), .phase_o(b_ph), .is_data_o(b_ok));

    assign out_ph = pair_phase(y_v, y_r);
    assign trig   = a_ok && b_ok && (a_ph == b_ph) && (a_ph != out_ph);
    assign wr_ok  = cfg_we && (st_q == ST_IDLE);

    lut_cfg_store #(.NUM_CTX(NUM_CTX), .ENT(ENT)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok),
        .wr_addr (cfg_addr),
        .wr_bit  (cfg_din),
        .planes  (planes_w)
    );

    lut_plane_sel #(.NUM_CTX(NUM_CTX), .ENT(ENT)) u_sel (
        .planes (planes_w),
        .ctx    (ctx_q),
        .idx    (idx_q),
        .bit_o  (sel_bit)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (trig) st_d = ST_EVAL;
            ST_EVAL: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // operand capture on the IDLE->EVAL transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            ctx_q <= '0;
            ph_q  <= 1'b0;
        end else if (st_q == ST_IDLE && trig) begin
            idx_q <= {a_dat, b_dat};
            ctx_q <= ctx_id;
            ph_q  <= a_ph;
        end
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_v <= 1'b0;
            y_r <= 1'b0;
        end else if (st_q == ST_EVAL) begin
            y_v <= sel_bit;
            y_r <= sel_bit ^ ph_q;
        end
    end
endmodule

// File: rtl/phase_lut_mc_chk.sv
module phase_lut_mc_chk #(
    parameter int NBITS = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input plut_pkg::lut_state_e st,
    input logic                 a_v,
    input logic                 a_r,
    input logic                 a_c,
    input logic                 b_v,
    input logic                 b_r,
    input logic                 b_c,
    input logic                 ph_q,
    input logic [NBITS-1:0]     planes,
    input logic                 y_v,
    input logic                 y_r
);
    import plut_pkg::*;

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_IDLE: assert (y_v == 1'b0 && y_r == 1'b0 && planes == '0 && st == ST_IDLE); // R1
        end
    end

    AST_EVAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_EVAL |=> st == ST_IDLE); // R3

    AST_OUT_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_EVAL |=> (y_v ^ y_r) == $past(ph_q)); // R5

    AST_HOLD_OUTSIDE_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        st != ST_EVAL |=> $stable(y_v) && $stable(y_r)); // R6

    AST_SPLIT_PHASE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && ((a_v ^ a_r) != (b_v ^ b_r))) |=> st == ST_IDLE); // R6

    AST_FLAG_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && (a_c || b_c)) |=> st == ST_IDLE); // R7

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_EVAL |=> $stable(planes)); // R8
endmodule

bind phase_lut_mc phase_lut_mc_chk #(.NBITS(NBITS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .st     (st_q),
    .a_v    (a_v),
    .a_r    (a_r),
    .a_c    (a_c),
    .b_v    (b_v),
    .b_r    (b_r),
    .b_c    (b_c),
    .ph_q   (ph_q),
    .planes (planes_w),
    .y_v    (y_v),
    .y_r    (y_r)
);

// File: tb/sim_phase_lut_mc.sv
module sim_phase_lut_mc;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_v = 0, a_r = 0, a_c = 0, b_v = 0, b_r = 0, b_c = 0;
    logic [2:0] ctx_id = '0;
    logic cfg_we = 0;
    logic [4:0] cfg_addr = '0;
    logic cfg_din = 0;
    logic y_v, y_r;

    int n_tests = 0;
    int n_fail = 0;
    logic tbl [32];
    logic ph_in = 1'b0;
    logic [1:0] y_exp = 2'b00;

    always #10 clk = ~clk;

    phase_lut_mc u0 (
        .clk(clk), .rst_n(rst_n),
        .a_v(a_v), .a_r(a_r), .a_c(a_c),
        .b_v(b_v), .b_r(b_r), .b_c(b_c),
        .ctx_id(ctx_id), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_din(cfg_din),
        .y_v(y_v), .y_r(y_r)
    );

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: y={v,r} actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [1:0] enc(input logic b, input logic ph);
        return {b, b ^ ph};
    endfunction

    task automatic cfg_write(input logic [4:0] addr, input logic d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = addr; cfg_din = d;
        @(negedge clk);
        cfg_we = 0;
        tbl[addr] = d;
    endtask

    task automatic drive_ops(input logic ad, input logic bd, input logic ph);
        a_v = ad; a_r = ad ^ ph;
        b_v = bd; b_r = bd ^ ph;
    endtask

    // token with a fresh phase; result checked two edges later
    task automatic send(input logic ad, input logic bd, input string req);
        logic np;
        np = ~ph_in;
        @(negedge clk);
        drive_ops(ad, bd, np);
        @(negedge clk);
        check({req, " (no early change, R3)"}, {y_v, y_r}, y_exp);
        @(negedge clk);
        y_exp = enc(tbl[{ctx_id, ad, bd}], np);
        ph_in = np;
        check(req, {y_v, y_r}, y_exp);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) tbl[i] = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset output", {y_v, y_r}, 2'b00);
        rst_n = 1;
        @(negedge clk);
        check("R1 after release", {y_v, y_r}, 2'b00);

        // R1: cleared tables give result 0 at phase 1
        ctx_id = 3'd6;
        send(1, 1, "R1 cleared table");

        // R2/R4/R5: XOR in context 3, AND in context 5
        for (int e = 0; e < 4; e++) cfg_write({3'd3, 2'(e)}, e[1] ^ e[0]);
        for (int e = 0; e < 4; e++) cfg_write({3'd5, 2'(e)}, e[1] & e[0]);
        cfg_write({3'd2, 2'b10}, 1'b1); // only a=1,b=0 set: checks operand order
        ctx_id = 3'd3;
        for (int e = 0; e < 4; e++) send(e[1], e[0], "R2 R4 R5 xor plane");
        ctx_id = 3'd5;
        for (int e = 0; e < 4; e++) send(e[1], e[0], "R4 R5 and plane");
        ctx_id = 3'd2;
        send(1, 0, "R4 operand a is msb");
        send(0, 1, "R4 operand b is lsb");

        // R6: split phases hold the output
        ctx_id = 3'd3;
        @(negedge clk);
        a_v = 1; a_r = 1 ^ ~ph_in;
        repeat (3) @(negedge clk);
        check("R6 split phase holds", {y_v, y_r}, y_exp);
        b_v = 0; b_r = 0 ^ ~ph_in;
        ph_in = ~ph_in;
        repeat (2) @(negedge clk);
        y_exp = enc(tbl[{3'd3, 2'b10}], ph_in);
        check("R6 evaluates once phases agree", {y_v, y_r}, y_exp);

        // R7: flag blocks evaluation
        @(negedge clk);
        a_c = 1;
        drive_ops(1, 1, ~ph_in);
        repeat (3) @(negedge clk);
        check("R7 one flag high holds", {y_v, y_r}, y_exp);
        b_c = 1;
        repeat (3) @(negedge clk);
        check("R7 both flags high holds", {y_v, y_r}, y_exp);
        a_c = 0; b_c = 0;
        ph_in = ~ph_in;
        repeat (2) @(negedge clk);
        y_exp = enc(tbl[{3'd3, 2'b11}], ph_in);
        check("R7 pending token after flags drop", {y_v, y_r}, y_exp);

        // R8: write during evaluation is discarded
        ctx_id = 3'd5;
        @(negedge clk);
        drive_ops(1, 1, ~ph_in);
        @(negedge clk);
        cfg_we = 1; cfg_addr = {3'd5, 2'b11}; cfg_din = 0;
        @(negedge clk);
        cfg_we = 0;
        ph_in = ~ph_in;
        y_exp = enc(1'b1, ph_in);
        check("R8 result during discarded write", {y_v, y_r}, y_exp);
        send(1, 1, "R8 table unchanged after write in EVAL");

        // R9: context change mid-evaluation
        ctx_id = 3'd3;
        @(negedge clk);
        drive_ops(0, 1, ~ph_in);
        @(negedge clk);
        ctx_id = 3'd5;
        @(negedge clk);
        ph_in = ~ph_in;
        y_exp = enc(tbl[{3'd3, 2'b01}], ph_in);
        check("R9 captured context used", {y_v, y_r}, y_exp);
        send(0, 1, "R9 new context on next evaluation");

        // random mix
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(0, 2) == 0) begin
                cfg_write(5'($urandom_range(0, 31)), 1'($urandom_range(0, 1)));
            end else begin
                ctx_id = 3'($urandom_range(0, 7));
                send(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R4 R5 random token");
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule